// File: doc/BRIEF.md
# ADC Conversion Result and Status Register

This block sits between an analog-to-digital converter core and the register bus. Each time the converter finishes, it pulses a result strobe carrying a 10-bit sample. The block stores that sample and marks it fresh. If an earlier sample was never collected, the block records that it has been overwritten. It also raises a sticky conversion-end flag.

The bus side has two controls. A read strobe on the data register clears the freshness and overwrite flags as a side effect. A one-bit write-one-to-clear strobe on the status register is the only way to drop the conversion-end flag. An interrupt request follows the conversion-end flag when the interrupt enable is set.

Bus decoding is done outside the block. The data read strobe and the status clear strobe arrive already qualified.

Top module: `adc_rslt_reg`

## Requirements
- R1: Bits 9:0 of the data word hold the last sample, loaded the cycle after a result strobe and held unchanged otherwise. All data word bits other than 9:0, 16 and 17 read 0.
- R2: Data word bit 17 (fresh) becomes 1 the cycle after a result strobe. It becomes 0 the cycle after a data read that has no result strobe in the same cycle.
- R3: Data word bit 16 (overwritten) becomes 1 after a result strobe that arrives while bit 17 is 1. It becomes 0 after a result strobe that arrives while bit 17 is 0. It also becomes 0 after a data read that has no strobe in the same cycle.
- R4: Status word bit 0 (conversion end) becomes 1 after every result strobe. It is cleared only by the status clear strobe. Data reads leave it unchanged, and the clear strobe does not touch bits 16 and 17.
- R5: Status bit 8 always equals data bit 17, and status bit 16 always equals data bit 16. All other status bits read 0.
- R6: The interrupt output is 1 exactly when the conversion-end flag is 1 and the interrupt enable is 1, with no register in between.
- R7: When a result strobe and a data read fall in the same cycle, the new sample is loaded and bit 17 stays 1. Bit 16 then takes the value bit 17 had before that cycle.
- R8: When a result strobe and the status clear strobe fall in the same cycle, the conversion-end flag ends up 1.
- R9: While reset is asserted, the sample, all flags and the interrupt output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_strobe_i | input | 1 | One-cycle pulse: a new sample is ready |
| res_value_i | input | 10 | Sample delivered with the strobe |
| data_rd_i | input | 1 | Bus read of the data word this cycle |
| stat_w1c_i | input | 1 | Bus write of 1 to the conversion-end status bit |
| irq_en_i | input | 1 | Interrupt enable control bit |
| data_word_o | output | 32 | Data register word (sample, overwritten, fresh) |
| status_word_o | output | 32 | Status word (conversion end, fresh mirror, overwritten mirror) |
| conv_end_o | output | 1 | Conversion-end flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block at its defaults: a 10-bit sample and a 32-bit word. With 10 bits, random samples differ from one another on almost every load, so a load that is missed or stale shows up in the result field. Directed samples of 0 and all ones exercise the field edges. The stimulus applies strobe, read, clear and enable with independent probabilities. This makes the same-cycle collisions of strobe with read and strobe with clear frequent, as well as back-to-back strobes that produce an overwrite.

// File: rtl/adc_rslt_pkg.sv
package adc_rslt_pkg;

  // Bit positions decoded by software.
  localparam int unsigned DW_OVR_BIT  = 16;
  localparam int unsigned DW_VLD_BIT  = 17;
  localparam int unsigned ST_END_BIT  = 0;
  localparam int unsigned ST_VLD_BIT  = 8;
  localparam int unsigned ST_OVR_BIT  = 16;

  typedef struct packed {
    logic valid;
    logic ovr;
    logic done;
  } flags_t;

  // Fresh flag: a load sets it; a read alone clears it.
  function automatic logic f_valid_nxt(logic vld, logic ld, logic rd);
    if (ld)      return 1'b1;
    else if (rd) return 1'b0;
    return vld;
  endfunction

  // Overwrite flag: a load takes the overwrite event; a read alone clears it.
  function automatic logic f_ovr_nxt(logic ovr, logic ovr_set, logic ld, logic rd);
    if (ld)      return ovr_set;
    else if (rd) return 1'b0;
    return ovr;
  endfunction

  // Conversion-end flag: a load sets it and wins over a clear.
  function automatic logic f_end_nxt(logic done, logic ld, logic clr);
    if (ld)       return 1'b1;
    else if (clr) return 1'b0;
    return done;
  endfunction

endpackage

// File: rtl/adc_rslt_hold.sv
module adc_rslt_hold #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_i,
  input  logic [RES_W-1:0] val_i,
  output logic [RES_W-1:0] res_o
);

  logic [RES_W-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (ld_i) res_q <= val_i;
  end

  assign res_o = res_q;

endmodule

// File: rtl/adc_rslt_flags.sv
module adc_rslt_flags
  import adc_rslt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ld_i,
  input  logic   rd_i,
  input  logic   ovr_set_i,
  input  logic   clr_i,
  output flags_t flags_o
);

  flags_t flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q.valid <= f_valid_nxt(flags_q.valid, ld_i, rd_i);
      flags_q.ovr   <= f_ovr_nxt(flags_q.ovr, ovr_set_i, ld_i, rd_i);
      flags_q.done  <= f_end_nxt(flags_q.done, ld_i, clr_i);
    end
  end

  assign flags_o = flags_q;

endmodule

// File: rtl/adc_rslt_pack.sv
module adc_rslt_pack
  import adc_rslt_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned WORD_W = 32
) (
  input  logic [RES_W-1:0]  res_i,
  input  flags_t            flags_i,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] stat_o
);

  always_comb begin
    data_o             = '0;
    data_o[RES_W-1:0]  = res_i;
    data_o[DW_OVR_BIT] = flags_i.ovr;
    data_o[DW_VLD_BIT] = flags_i.valid;
  end

  always_comb begin
    stat_o             = '0;
    stat_o[ST_END_BIT] = flags_i.done;
    stat_o[ST_VLD_BIT] = flags_i.valid;
    stat_o[ST_OVR_BIT] = flags_i.ovr;
  end

endmodule

// File: rtl/adc_rslt_reg.sv
module adc_rslt_reg
  import adc_rslt_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_strobe_i,
  input  logic [RES_W-1:0]  res_value_i,
  input  logic              data_rd_i,
  input  logic              stat_w1c_i,
  input  logic              irq_en_i,
  output logic [WORD_W-1:0] data_word_o,
  output logic [WORD_W-1:0] status_word_o,
  output logic              conv_end_o,
  output logic              irq_o
);

  logic [RES_W-1:0] res_q;
  flags_t           flags_q;
  logic             ovr_ev;   // a load lands on a sample nobody read

  assign ovr_ev = res_strobe_i & flags_q.valid;

  adc_rslt_hold #(.RES_W(RES_W)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (res_strobe_i),
    .val_i (res_value_i),
    .res_o (res_q)
  );

  adc_rslt_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (res_strobe_i),
    .rd_i      (data_rd_i),
    .ovr_set_i (ovr_ev),
    .clr_i     (stat_w1c_i),
    .flags_o   (flags_q)
  );

  adc_rslt_pack #(.RES_W(RES_W), .WORD_W(WORD_W)) u_pack (
    .res_i   (res_q),
    .flags_i (flags_q),
    .data_o  (data_word_o),
    .stat_o  (status_word_o)
  );

  assign conv_end_o = flags_q.done;
  assign irq_o      = flags_q.done & irq_en_i;

endmodule

// File: rtl/adc_rslt_chk.sv
module adc_rslt_chk
  import adc_rslt_pkg::*;
#(
  parameter int unsigned RES_W  = 10,
  parameter int unsigned WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_strobe_i,
  input logic [RES_W-1:0]  res_value_i,
  input logic              data_rd_i,
  input logic              stat_w1c_i,
  input logic              irq_en_i,
  input logic [WORD_W-1:0] data_word_o,
  input logic [WORD_W-1:0] status_word_o,
  input logic              conv_end_o,
  input logic              irq_o,
  input logic              ovr_ev
);

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !res_strobe_i |=> $stable(data_word_o[RES_W-1:0])); // R1

  AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    res_strobe_i |=> data_word_o[RES_W-1:0] == $past(res_value_i)); // R1

  AST_FRESH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    res_strobe_i |=> data_word_o[DW_VLD_BIT]); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_i && !res_strobe_i |=> !data_word_o[DW_VLD_BIT] && !data_word_o[DW_OVR_BIT]); // R2

  AST_OVERWRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_ev |=> data_word_o[DW_OVR_BIT]); // R3

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_end_o && !stat_w1c_i |=> conv_end_o); // R4

  AST_END_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    res_strobe_i && stat_w1c_i |=> conv_end_o); // R8

  AST_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    status_word_o[ST_VLD_BIT] == data_word_o[DW_VLD_BIT] &&
    status_word_o[ST_OVR_BIT] == data_word_o[DW_OVR_BIT]); // R5

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_word_o[ST_END_BIT] && irq_en_i); // R6

endmodule

bind adc_rslt_reg adc_rslt_chk #(.RES_W(RES_W), .WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .res_strobe_i  (res_strobe_i),
  .res_value_i   (res_value_i),
  .data_rd_i     (data_rd_i),
  .stat_w1c_i    (stat_w1c_i),
  .irq_en_i      (irq_en_i),
  .data_word_o   (data_word_o),
  .status_word_o (status_word_o),
  .conv_end_o    (conv_end_o),
  .irq_o         (irq_o),
  .ovr_ev        (ovr_ev)
);

// File: tb/sim_adc_rslt_reg.sv
module sim_adc_rslt_reg;

  localparam int RW = 10;
  localparam int WW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld = 1'b0;
  logic [RW-1:0] val = '0;
  logic          rd = 1'b0;
  logic          clr = 1'b0;
  logic          en = 1'b0;
  logic [WW-1:0] dword, sword;
  logic          cend, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [RW-1:0] m_res = '0;
  logic          m_vld = 1'b0, m_ovr = 1'b0, m_end = 1'b0;

  always #4 clk = ~clk;

  adc_rslt_reg u0 (
    .clk(clk), .rst_n(rst_n), .res_strobe_i(ld), .res_value_i(val),
    .data_rd_i(rd), .stat_w1c_i(clr), .irq_en_i(en),
    .data_word_o(dword), .status_word_o(sword), .conv_end_o(cend), .irq_o(irq)
  );

  function automatic logic [WW-1:0] want_data(logic [RW-1:0] r, logic v, logic o);
    logic [WW-1:0] w = '0;
    w[RW-1:0] = r;
    w[16] = o;
    w[17] = v;
    return w;
  endfunction

  function automatic logic [WW-1:0] want_stat(logic e, logic v, logic o);
    logic [WW-1:0] w = '0;
    w[0]  = e;
    w[8]  = v;
    w[16] = o;
    return w;
  endfunction

  task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  task automatic check_all();
    logic [WW-1:0] d = dword;
    chk("R1 sample field", {{(WW-RW){1'b0}}, d[RW-1:0]}, {{(WW-RW){1'b0}}, m_res});
    chk("R1 zero bits", d & ~(32'h0003_0000 | {{(WW-RW){1'b0}}, {RW{1'b1}}}), '0);
    chk("R2 fresh bit", {31'b0, d[17]}, {31'b0, m_vld});
    chk("R3 overwrite bit", {31'b0, d[16]}, {31'b0, m_ovr});
    chk("R4 conv end", {31'b0, cend}, {31'b0, m_end});
    chk("R5 status word", sword, want_stat(m_end, m_vld, m_ovr));
    chk("R6 irq", {31'b0, irq}, {31'b0, m_end & en});
  endtask

  // One clock: drive at negedge, model updates at the edge, check at next negedge.
  task automatic step(logic s, logic [RW-1:0] v, logic r, logic c, logic e);
    ld = s; val = v; rd = r; clr = c; en = e;
    @(posedge clk);
    if (s) begin
      m_ovr = m_vld;          // R7: judged on the state before any read
      m_vld = 1'b1;
      m_res = v;
      m_end = 1'b1;           // R8: load beats clear
    end else begin
      if (r) begin m_vld = 1'b0; m_ovr = 1'b0; end
      if (c) m_end = 1'b0;
    end
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R9: everything zero under reset
    chk("R9 data word in reset", dword, '0);
    chk("R9 status word in reset", sword, '0);
    chk("R9 irq in reset", {31'b0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    step(1, 10'h3FF, 0, 0, 1);   // R1 all ones, R2 set, R6 irq with enable
    chk("R1 all-ones load", dword, want_data(10'h3FF, 1, 0));
    step(0, 10'h155, 0, 0, 0);   // R1 hold without strobe, R6 enable off
    step(1, 10'h000, 0, 0, 1);   // R3 overwrite on unread sample
    chk("R3 overwrite set", {31'b0, dword[16]}, 32'd1);
    step(0, 10'h0, 1, 0, 1);     // R2 R3 read clears; R4 read leaves end flag
    chk("R4 end survives read", {31'b0, cend}, 32'd1);
    step(1, 10'h2A5, 1, 0, 1);   // R7 strobe with read, fresh was 0
    chk("R7 fresh kept, no overwrite", dword, want_data(10'h2A5, 1, 0));
    step(1, 10'h15A, 1, 0, 1);   // R7 strobe with read, fresh was 1
    chk("R7 overwrite from pre-read state", dword, want_data(10'h15A, 1, 1));
    step(0, 10'h0, 0, 1, 1);     // R4 clear drops end flag, not fresh/overwrite
    chk("R4 clear leaves data flags", dword, want_data(10'h15A, 1, 1));
    step(1, 10'h001, 0, 1, 1);   // R8 load and clear together
    chk("R8 end flag set", {31'b0, cend}, 32'd1);

    void'($urandom(32'd5050));
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 100) < 40, RW'($urandom), ($urandom % 100) < 30,
           ($urandom % 100) < 20, ($urandom % 100) < 60);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule